// File: doc/BRIEF.md
# Serial Control/Status Frame Port

This block is the serial slave port of an eight-channel output driver. A host frames a transfer with an active-low select line. While selected, it clocks a control word in on a data input and reads a status word out on a data output, one bit per serial clock. The status word is snapshotted from a parallel input when the select line falls. The received control word goes to a parallel control latch only when the select line rises.

A length filter guards the latch. The control word is committed only if the frame held a nonzero whole multiple of eight serial clocks. A frame cut short by noise, or one that is too long by a few clocks, therefore leaves the outputs as they were. Frames of sixteen or more clocks pass through the shift register: the bits clocked out after the first eight are the first bits that were clocked in. This allows several ports to share one serial chain.

The serial lines are sampled by a fast system clock. Each line passes through a two-flop synchronizer, and the port acts on the edges it sees on the synchronized serial clock and select. The output stage is split into a data bit and an output enable, which stand for a three-state pin.

Top module: `spi_frame_port`

## Requirements
- R1: While rst_ni is low, and after it is released, ctrl_o is 0 (all channels off) and sdo_oe_o is 0.
- R2: sdo_oe_o is 1 while ncs_i is low and 0 while ncs_i is high, following a change of ncs_i within 3 system clock cycles.
- R3: On a falling edge of ncs_i, stat_i is captured. After each rising edge of sck_i, sdo_o carries the captured bits, stat_i[7] first and stat_i[0] eighth.
- R4: Each falling edge of sck_i while selected shifts in sdi_i. After a frame of exactly 8 clocks, ctrl_o[7] holds the first bit received and ctrl_o[0] the last.
- R5: On a rising edge of ncs_i, ctrl_o takes the last 8 bits received if the frame held 8, 16 or any other nonzero multiple of 8 falling sck_i edges.
- R6: A frame of 0 clocks, or of a count that is not a multiple of 8, leaves ctrl_o unchanged.
- R7: A change of stat_i after the falling edge of ncs_i does not alter the bits shifted out on sdo_o in that frame.
- R8: In a frame longer than 8 clocks, the bit on sdo_o after rising edge k (k counted from 0, k >= 8) is the sdi_i bit received on falling edge k-8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ncs_i | input | 1 | Serial select, active low |
| sck_i | input | 1 | Serial clock, low whenever ncs_i changes |
| sdi_i | input | 1 | Serial data in |
| stat_i | input | 8 | Parallel status word |
| sdo_o | output | 1 | Serial data out bit |
| sdo_oe_o | output | 1 | Serial data out enable; 0 means high impedance |
| ctrl_o | output | 8 | Output control latch |

## Verification
A change on any serial input is seen by the logic after the two synchronizer flops. The register it affects updates on the third system clock edge. sdo_oe_o follows after the second edge, because it is decoded straight from the synchronized select. The bench drives each serial level on a falling system-clock edge and holds it for four system cycles. It samples sdo_o, sdo_oe_o and ctrl_o on the falling edge at the end of that hold, one cycle after the latest result is due. The frame length is swept from 0 to 17 clocks over changing data and status patterns. The expected shift-out sequence and the latch value are computed from the bit index and the frame length.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
  localparam int unsigned WORD_W  = 8;
  localparam int unsigned SYNC_N  = 3;  // ncs, sck, sdi
  localparam int unsigned IDX_NCS = 0;
  localparam int unsigned IDX_SCK = 1;
  localparam int unsigned IDX_SDI = 2;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
        s3_q <= RST_VAL[g];
      end else begin
        s1_q <= raw_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign lvl_o[g]  = s2_q;
    assign rise_o[g] = s2_q & ~s3_q;
    assign fall_o[g] = ~s2_q & s3_q;
  end
endmodule

// File: rtl/spi_bit_counter.sv
module spi_bit_counter #(
  parameter int unsigned DW = 8,
  localparam int unsigned CW = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  output logic whole_o
);
  logic [CW-1:0] cnt_q;
  logic          wrapped_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      wrapped_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q     <= '0;
      wrapped_q <= 1'b0;
    end else if (step_i) begin
      if (cnt_q == CW'(DW-1)) begin
        cnt_q     <= '0;
        wrapped_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign whole_o = wrapped_q && (cnt_q == '0);

  // R6
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !whole_o);
  // R5
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i && cnt_q == CW'(DW-1)) |=> whole_o);
endmodule

// File: rtl/spi_shift_reg.sv
module spi_shift_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] par_i,
  input  logic          shift_i,
  input  logic          ser_i,
  input  logic          drive_i,
  output logic [DW-1:0] word_o,
  output logic          sdo_o
);
  logic [DW-1:0] sr_q;
  logic          sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      sdo_q <= 1'b0;
    end else if (load_i) begin
      sr_q  <= par_i;
      sdo_q <= par_i[DW-1];
    end else begin
      if (shift_i) sr_q  <= {sr_q[DW-2:0], ser_i};
      if (drive_i) sdo_q <= sr_q[DW-1];
    end
  end

  assign word_o = sr_q;
  assign sdo_o  = sdo_q;

  // R3
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (word_o == $past(par_i)) && (sdo_o == $past(par_i[DW-1])));
  // R4
  shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> word_o[0] == $past(ser_i));
endmodule

// File: rtl/spi_frame_port.sv
module spi_frame_port
  import spi_frame_pkg::*;
#(
  parameter int unsigned DW = WORD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ncs_i,
  input  logic          sck_i,
  input  logic          sdi_i,
  input  logic [DW-1:0] stat_i,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  output logic [DW-1:0] ctrl_o
);
  logic [SYNC_N-1:0] lvl, rise, fall;
  logic              sel, ncs_fall, ncs_rise, sck_rise, sck_fall;
  logic              whole;
  logic [DW-1:0]     word;
  logic [DW-1:0]     ctrl_q;

  spi_in_sync #(.N(SYNC_N), .RST_VAL(3'b001)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i ({sdi_i, sck_i, ncs_i}),
    .lvl_o (lvl),
    .rise_o(rise),
    .fall_o(fall)
  );

  assign sel      = ~lvl[IDX_NCS];
  assign ncs_fall = fall[IDX_NCS];
  assign ncs_rise = rise[IDX_NCS];
  assign sck_rise = rise[IDX_SCK] & sel;
  assign sck_fall = fall[IDX_SCK] & sel;

  spi_bit_counter #(.DW(DW)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(ncs_fall),
    .step_i (sck_fall),
    .whole_o(whole)
  );

  spi_shift_reg #(.DW(DW)) i_sr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ncs_fall),
    .par_i  (stat_i),
    .shift_i(sck_fall),
    .ser_i  (lvl[IDX_SDI]),
    .drive_i(sck_rise),
    .word_o (word),
    .sdo_o  (sdo_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ctrl_q <= '0;
    else if (ncs_rise && whole) ctrl_q <= word;
  end

  assign ctrl_o   = ctrl_q;
  assign sdo_oe_o = sel;

  // R6
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ncs_rise && whole) |=> $stable(ctrl_o));
  // R5
  ctrl_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ncs_rise && whole) |=> ctrl_o == $past(word));
  // R2
  oe_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ncs_fall |-> sdo_oe_o);
endmodule

// File: tb/test_spi_frame_port.sv
module test_spi_frame_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ncs = 1'b1;
  logic       sck = 1'b0;
  logic       sdi = 1'b0;
  logic [7:0] stat = '0;
  logic       sdo, sdo_oe;
  logic [7:0] ctrl;

  int unsigned total = 0;
  int unsigned bad = 0;
  logic [7:0]  exp_ctrl = '0;

  always #2.5 clk = ~clk;

  spi_frame_port i_spi_frame_port (
    .clk_i(clk), .rst_ni(rst_n), .ncs_i(ncs), .sck_i(sck), .sdi_i(sdi),
    .stat_i(stat), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .ctrl_o(ctrl)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Run one frame of n clocks; seq[i] is the sdi bit on falling edge i.
  task automatic frame(input int n, input logic [23:0] seq, input logic [7:0] st,
                       input bit disturb);
    logic [7:0] new_ctrl;
    stat = st;
    ncs  = 1'b0;
    wait_cyc(4);
    chk({7'b0, sdo_oe}, 8'h01, "R2 oe while selected");
    if (disturb) stat = ~st;  // R7: late status change must not leak
    for (int i = 0; i < n; i++) begin
      sck = 1'b1;
      sdi = seq[i];
      wait_cyc(4);
      if (i < 8) chk({7'b0, sdo}, {7'b0, st[7-i]}, disturb ? "R7 snapshot" : "R3 status out");
      else       chk({7'b0, sdo}, {7'b0, seq[i-8]}, "R8 pass-through");
      sck = 1'b0;
      wait_cyc(4);
    end
    ncs = 1'b1;
    wait_cyc(4);
    chk({7'b0, sdo_oe}, 8'h00, "R2 hi-z when deselected");
    if (n > 0 && n % 8 == 0) begin
      for (int k = 0; k < 8; k++) new_ctrl[7-k] = seq[n-8+k];
      exp_ctrl = new_ctrl;
      chk(ctrl, exp_ctrl, (n == 8) ? "R4 bit order" : "R5 multiple commit");
    end else begin
      chk(ctrl, exp_ctrl, "R6 length filter hold");
    end
  endtask

  bit done = 1'b0;

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    // R1
    chk(ctrl, 8'h00, "R1 reset ctrl");
    chk({7'b0, sdo_oe}, 8'h00, "R1 reset oe");
    rst_n = 1'b1;
    wait_cyc(4);
    chk(ctrl, 8'h00, "R1 after release");
    frame(8, 24'h0000A5, 8'h3C, 1'b0);
    for (int n = 0; n <= 17; n++)
      frame(n, 24'(n * 40503 + 12345), 8'((n * 29 + 77) ^ 8'h5A), 1'b0);
    frame(8, 24'h00005E, 8'hC3, 1'b1);
    frame(16, 24'h00F00F, 8'h81, 1'b1);
    frame(24, 24'h9AC3E1, 8'h66, 1'b0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule